// File: doc/BRIEF.md
# DMA Channel Enable and Structure-Select Register Bank

This block holds two per-channel control vectors for a DMA engine with up to 24 channels. The first is a run-enable bit for each channel. The second is a structure-select bit that picks either the primary or the alternate descriptor. Software never writes a vector directly. Each vector has one address that sets bits and another that clears them, so a single write can change chosen channels without a read-modify-write.

The DMA engine also changes the bits itself. A completion pulse for a channel drops that channel's enable. A toggle pulse inverts the channel's structure select, which is what ping-pong and scatter-gather sequencing need. Both vectors drive the engine directly. The register bus is minimal: a write strobe, a byte address, write data, and combinational read data.

Top module: `dma_chan_ctrl_regs`

## Requirements
- R1: Read data bits [31:NCH] are always zero. Bit n of every register belongs to channel n, and write-data bits [31:NCH] are ignored.
- R2: After reset, both the enable vector and the structure-select vector are all zero.
- R3: A write to byte offset 0x0 (enable-set) sets each enable bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A read of offset 0x0 returns the enable vector.
- R4: A write to offset 0x4 (enable-clear) clears each enable bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A read of offset 0x4 returns zero.
- R5: A pulse on `done_i[n]` clears enable bit n at the next clock edge, even when a software set of that bit happens in the same cycle.
- R6: A write to offset 0x8 (alt-set) sets each select bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A read of offset 0x8 returns the select vector.
- R7: A write to offset 0xC (alt-clear) clears each select bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A read of offset 0xC returns zero.
- R8: A pulse on `alt_toggle_i[n]` inverts select bit n at the next clock edge and overrides any software write to that bit in the same cycle.
- R9: Writes take effect at the clock edge that samples the strobe, and never before it. Reads are combinational. Without a write or an event, both vectors hold their value. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (4) | Byte address; bits [3:2] select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| done_i | input | NCH (24) | Per-channel cycle-complete pulses |
| alt_toggle_i | input | NCH (24) | Per-channel structure-select toggle pulses |
| enable_o | output | NCH (24) | Channel enable vector |
| alt_sel_o | output | NCH (24) | Structure-select vector (1 = alternate) |

## Verification
The bench aims a completion pulse and a software enable-set at the same bit in the same cycle. A design with the wrong priority would leave the finished channel running. It also aims a toggle pulse at a bit that is being written through alt-clear in the same cycle. A design that let software win would stall ping-pong on one descriptor. Writes of zero and writes of all ones to reserved bits confirm that unselected channels and upper bits never change. Reads of the clear addresses confirm they return zero and do not mirror a vector. Random traffic that mixes writes with sparse events is compared against a bench model every cycle, which catches any wrong decode or a write that lands a cycle early.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    REG_ENA_SET = 2'd0,
    REG_ENA_CLR = 2'd1,
    REG_ALT_SET = 2'd2,
    REG_ALT_CLR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic ena_set;
    logic ena_clr;
    logic alt_set;
    logic alt_clr;
  } wr_strb_t;
endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
  import dma_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output wr_strb_t          strb_o
);
  logic [ADDR_W-1:0] addr_unused;
  assign addr_unused = addr_i;

  assign sel_o = reg_sel_e'(addr_i[3:2]);

  always_comb begin
    strb_o         = '0;
    strb_o.ena_set = wr_en_i && (sel_o == REG_ENA_SET);
    strb_o.ena_clr = wr_en_i && (sel_o == REG_ENA_CLR);
    strb_o.alt_set = wr_en_i && (sel_o == REG_ALT_SET);
    strb_o.alt_clr = wr_en_i && (sel_o == REG_ALT_CLR);
  end
endmodule

// File: rtl/dma_ctrl_bitvec.sv
// Per-channel W1S/W1C bit vector; hardware event either clears or toggles a bit.
module dma_ctrl_bitvec #(
  parameter int unsigned NCH       = 24,
  parameter bit          HW_TOGGLE = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sw_set_i,
  input  logic           sw_clr_i,
  input  logic [NCH-1:0] wdata_i,
  input  logic [NCH-1:0] hw_evt_i,
  output logic [NCH-1:0] q_o
);
  logic [NCH-1:0] q_q, q_d;

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    logic sw_val;
    always_comb begin
      sw_val = q_q[i];
      if (sw_set_i && wdata_i[i])      sw_val = 1'b1;
      else if (sw_clr_i && wdata_i[i]) sw_val = 1'b0;
    end
    if (HW_TOGGLE) begin : g_tog
      assign q_d[i] = hw_evt_i[i] ? ~q_q[i] : sw_val;
    end else begin : g_clr
      assign q_d[i] = hw_evt_i[i] ? 1'b0 : sw_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dma_ctrl_rdmux.sv
module dma_ctrl_rdmux
  import dma_ctrl_pkg::*;
#(
  parameter int unsigned NCH = 24
) (
  input  reg_sel_e          sel_i,
  input  logic [NCH-1:0]    ena_i,
  input  logic [NCH-1:0]    alt_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      REG_ENA_SET: rdata_o[NCH-1:0] = ena_i;
      REG_ALT_SET: rdata_o[NCH-1:0] = alt_i;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_ctrl_regs.sv
module dma_chan_ctrl_regs
  import dma_ctrl_pkg::*;
#(
  parameter int unsigned NCH    = 24,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NCH-1:0]    done_i,
  input  logic [NCH-1:0]    alt_toggle_i,
  output logic [NCH-1:0]    enable_o,
  output logic [NCH-1:0]    alt_sel_o
);
  reg_sel_e sel;
  wr_strb_t strb;

  if (NCH < DATA_W) begin : g_rsv
    logic rsv_unused;
    assign rsv_unused = ^wdata_i[DATA_W-1:NCH];
  end

  dma_ctrl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .sel_o   (sel),
    .strb_o  (strb)
  );

  dma_ctrl_bitvec #(.NCH(NCH), .HW_TOGGLE(1'b0)) u_ena (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_set_i (strb.ena_set),
    .sw_clr_i (strb.ena_clr),
    .wdata_i  (wdata_i[NCH-1:0]),
    .hw_evt_i (done_i),
    .q_o      (enable_o)
  );

  dma_ctrl_bitvec #(.NCH(NCH), .HW_TOGGLE(1'b1)) u_alt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_set_i (strb.alt_set),
    .sw_clr_i (strb.alt_clr),
    .wdata_i  (wdata_i[NCH-1:0]),
    .hw_evt_i (alt_toggle_i),
    .q_o      (alt_sel_o)
  );

  dma_ctrl_rdmux #(.NCH(NCH)) u_rd (
    .sel_i   (sel),
    .ena_i   (enable_o),
    .alt_i   (alt_sel_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/dma_chan_ctrl_regs_chk.sv
module dma_chan_ctrl_regs_chk #(
  parameter int unsigned NCH    = 24,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NCH-1:0]    done_i,
  input logic [NCH-1:0]    alt_toggle_i,
  input logic [NCH-1:0]    enable_o,
  input logic [NCH-1:0]    alt_sel_o
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o >> NCH) == 32'd0); // R1

  AST_CLR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[2] |-> rdata_o == 32'd0); // R4

  AST_ENA_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[3:2] == 2'd0) |=>
      ((enable_o & ($past(wdata_i[NCH-1:0]) & ~$past(done_i)))
        == ($past(wdata_i[NCH-1:0]) & ~$past(done_i)))); // R3

  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i != '0) |=> ((enable_o & $past(done_i)) == '0)); // R5

  AST_ALT_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_toggle_i != '0) |=>
      (((alt_sel_o ^ $past(alt_sel_o)) & $past(alt_toggle_i)) == $past(alt_toggle_i))); // R8

  AST_ENA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && done_i == '0) |=> $stable(enable_o)); // R9

  AST_ALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && alt_toggle_i == '0) |=> $stable(alt_sel_o)); // R9
endmodule

bind dma_chan_ctrl_regs dma_chan_ctrl_regs_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .done_i       (done_i),
  .alt_toggle_i (alt_toggle_i),
  .enable_o     (enable_o),
  .alt_sel_o    (alt_sel_o)
);

// File: tb/dma_chan_ctrl_regs_test.sv
`timescale 1ns/1ps
module dma_chan_ctrl_regs_test;
  localparam int NCH = 24;
  localparam int AW  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic [NCH-1:0] done, tog, en, alt;

  logic [NCH-1:0] m_en, m_alt;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_chan_ctrl_regs #(.NCH(NCH), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_i(done), .alt_toggle_i(tog),
    .enable_o(en), .alt_sel_o(alt)
  );

  function automatic logic [NCH-1:0] nxt_en(logic [NCH-1:0] cur, logic w, logic [AW-1:0] a,
                                            logic [31:0] d, logic [NCH-1:0] dn);
    logic [NCH-1:0] n = cur;
    if (w && a[3:2] == 2'd0) n = n | d[NCH-1:0];
    if (w && a[3:2] == 2'd1) n = n & ~d[NCH-1:0];
    return n & ~dn;
  endfunction

  function automatic logic [NCH-1:0] nxt_alt(logic [NCH-1:0] cur, logic w, logic [AW-1:0] a,
                                             logic [31:0] d, logic [NCH-1:0] t);
    logic [NCH-1:0] n = cur;
    if (w && a[3:2] == 2'd2) n = n | d[NCH-1:0];
    if (w && a[3:2] == 2'd3) n = n & ~d[NCH-1:0];
    return (n & ~t) | (~cur & t);
  endfunction

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    case (a[3:2])
      2'd0:    return {8'h00, m_en};
      2'd2:    return {8'h00, m_alt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, update model at posedge, return at next negedge
  task automatic step(logic w, logic [AW-1:0] a, logic [31:0] d,
                      logic [NCH-1:0] dn, logic [NCH-1:0] t);
    wr_en = w; addr = a; wdata = d; done = dn; tog = t;
    @(posedge clk);
    m_en  = nxt_en(m_en, w, a, d, dn);
    m_alt = nxt_alt(m_alt, w, a, d, t);
    @(negedge clk);
    wr_en = 1'b0; done = '0; tog = '0;
  endtask

  task automatic check_all(string req);
    check(req, "enable_o", {8'h00, en}, {8'h00, m_en});
    check(req, "alt_sel_o", {8'h00, alt}, {8'h00, m_alt});
    for (int k = 0; k < 4; k++) begin
      addr = AW'(k * 4 + (k & 1) * 2); // also vary ignored low bits
      #1;
      check(req, $sformatf("rdata@%0h", addr), rdata, exp_rd(addr));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; done = '0; tog = '0;
    m_en = '0; m_alt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R2");

    // R3 set, plus reserved write bits ignored (R1)
    step(1'b1, 4'h0, 32'hFF0F_00F3, '0, '0);
    check("R3", "enable after set", {8'h00, en}, 32'h000F_00F3);
    check_all("R1");
    step(1'b1, 4'h0, 32'h0, '0, '0);
    check("R3", "zero write no effect", {8'h00, en}, 32'h000F_00F3);

    // R4 clear
    step(1'b1, 4'h4, 32'h0, '0, '0);
    check("R4", "zero write no effect", {8'h00, en}, 32'h000F_00F3);
    step(1'b1, 4'h4, 32'h0000_0013, '0, '0);
    check("R4", "enable after clear", {8'h00, en}, 32'h000F_00E0);
    addr = 4'h4; #1;
    check("R4", "clear addr reads zero", rdata, 32'h0);

    // R5 done beats set
    step(1'b1, 4'h0, 32'h0000_0110, 24'h000110, '0);
    check("R5", "done over set", {8'h00, en}, 32'h000F_00E0);
    step(1'b0, 4'h0, 32'h0, 24'h080000, '0);
    check("R5", "done clears", {8'h00, en}, 32'h0007_00E0);

    // R6/R7 select
    step(1'b1, 4'h8, 32'h8000_0007, '0, '0);
    check("R6", "alt after set", {8'h00, alt}, 32'h0000_0007);
    addr = 4'h8; #1;
    check("R6", "alt readback", rdata, 32'h0000_0007);
    step(1'b1, 4'hC, 32'h0000_0003, '0, '0);
    check("R7", "alt after clear", {8'h00, alt}, 32'h0000_0004);
    addr = 4'hC; #1;
    check("R7", "alt-clear reads zero", rdata, 32'h0);

    // R8 toggle beats software
    step(1'b1, 4'hC, 32'h0000_0001, 24'h0, 24'h000001);
    check("R8", "toggle over clear", {8'h00, alt}, 32'h0000_0005);
    step(1'b1, 4'h8, 32'h0000_0004, 24'h0, 24'h000004);
    check("R8", "toggle over set", {8'h00, alt}, 32'h0000_0001);

    // R9 write not visible before edge
    wr_en = 1'b1; addr = 4'h0; wdata = 32'h00FF_FFFF; #1;
    check("R9", "no early update", {8'h00, en}, {8'h00, m_en});
    @(posedge clk);
    m_en = nxt_en(m_en, 1'b1, 4'h0, 32'h00FF_FFFF, '0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R9", "update after edge", {8'h00, en}, 32'h00FF_FFFF);
    step(1'b0, 4'h0, 32'h0, '0, '0);
    check_all("R9");

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      step($urandom % 2 == 1, a, $urandom,
           NCH'($urandom & $urandom & $urandom),
           NCH'($urandom & $urandom & $urandom));
      check("R5", "rand enable", {8'h00, en}, {8'h00, m_en});
      check("R8", "rand alt", {8'h00, alt}, {8'h00, m_alt});
      addr = a; #1;
      check("R1", "rand read", rdata, exp_rd(a));
    end

    summary();
  end
endmodule